// File: doc/BRIEF.md
# Hardware-Sequenced SPI Flash Engine

This block lets software run a complete serial flash transaction by writing a few registers. Software first loads a 24-bit flash address and, for program cycles, the outgoing bytes into a 64-byte buffer of sixteen 32-bit words. It then writes one control word. That word picks a numbered cycle type, gives a byte count and sets the start bit. The engine turns the cycle type into fixed SPI command bytes. Where the cycle needs them, it also adds the write-enable frame, the three address bytes and the status polling that follows a program or erase. It drives a single flash device in SPI mode 0.

Status sits in the same control word as the command fields. Software clears the done, cycle-error and access-error flags by writing 1 to them, usually in the same write that starts the next cycle. An external protection checker drives the access-error input. A sticky lock bit refuses the cycle that rewrites the flash status register.

Top module: `spi_hwseq_engine`

## Requirements
- R1: After reset, the control word at byte offset 0x04 and the address register at 0x08 read 0, chip select is high and SCK is low.
- R2: Cycle type 0 (read) sends opcode 0x03, then address bits 23:0 most significant byte first, then count+1 dummy bytes. The bytes received go into the buffer (offsets 0x10..0x4C), least-significant byte first.
- R3: Cycle type 2 (program) sends 0x06 in a frame of its own, then 0x02, the address and count+1 buffer bytes. It then repeats the two-byte frame 0x05, 0x00 until bit 0 of the received status byte is 0, and only then sets done.
- R4: Cycle types 3 and 4 send 0x06, then 0x20 or 0xD8 with the address and no data bytes, whatever the count field (bits 29:24) holds. They then poll as in R3.
- R5: Cycle types 6 (0x9F) and 8 (0x05) send no address and read count+1 bytes into the buffer. Cycle type 7 sends 0x06, then 0x01 with count+1 buffer bytes, then polls.
- R6: Control bit 5 reads 1 from the edge that starts an accepted cycle until the cycle ends, when done (bit 0) is set. The start bit (bit 16) always reads 0.
- R7: Bits 0 (done), 1 (cycle error) and 2 (access error) are cleared by writing 1 to them, including in the same write that starts a cycle.
- R8: If the access-error input is high when the start bit is written, bit 2 is set, no SPI frame is sent and bit 5 stays 0.
- R9: Lock bit 15, once written to 1, stays 1 until reset. While it is set, a cycle of type 7 sets bit 1 and sends nothing.
- R10: A cycle type outside {0,2,3,4,6,7,8} sets bit 1 and sends nothing.
- R11: While bit 5 is 1, writes to the control fields, the address and the buffer are ignored, and a start write launches nothing.
- R12: SCK is low whenever chip select is high. MOSI changes on the falling edge and MISO is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; SCK runs at half this rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 7 | Byte offset of the register access |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| acc_err_in | input | 1 | Protection checker verdict for the pending cycle |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The properties assume register writes arrive one word per cycle. They also assume the access-error input is steady during the cycle that carries the start bit. The bench drives both from the falling clock edge, so this holds. The checks also rely on a flash that answers only in mode 0 and shifts its reply on SCK falling edges. The bench flash model behaves this way, and it reports busy for a programmed number of status polls before it reports ready. Any frame the engine sends is compared, byte by byte and frame boundary by frame boundary, against the queue the driver filled. A launched cycle that should have been refused therefore shows up as an unexpected byte.

// File: rtl/spi_hwseq_engine.sv
module spi_hwseq_engine #(
  parameter int GAP_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        acc_err_in,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int NWORDS = 16;
  localparam logic [3:0] T_RD = 4'd0, T_PP = 4'd2, T_E4 = 4'd3, T_E64 = 4'd4,
                         T_ID = 4'd6, T_WS = 4'd7, T_RS = 4'd8;

  typedef enum logic [3:0] {S_IDLE, S_GAP, S_WREN, S_OPC, S_ADR, S_WDAT,
                            S_RDAT, S_PCMD, S_PRD} st_t;

  st_t st, st_n, ret, ret_n;
  logic [3:0]  typ, hc;
  logic [5:0]  cnt, bcnt, bcnt_n;
  logic [7:0]  sh, tx_n, gap;
  logic [23:0] faddr;
  logic [31:0] buf_q [NWORDS];
  logic        lock, done, cerr, aerr, busy, fin, bdone, load;
  logic [7:0]  rx;

  function automatic logic shifting(st_t s);
    return s inside {S_WREN, S_OPC, S_ADR, S_WDAT, S_RDAT, S_PCMD, S_PRD};
  endfunction
  function automatic logic valid_of(logic [3:0] t);
    return t inside {T_RD, T_PP, T_E4, T_E64, T_ID, T_WS, T_RS};
  endfunction
  function automatic logic wren_of(logic [3:0] t);
    return t inside {T_PP, T_E4, T_E64, T_WS};
  endfunction
  function automatic logic [7:0] op_of(logic [3:0] t);
    case (t)
      T_RD:    return 8'h03;
      T_PP:    return 8'h02;
      T_E4:    return 8'h20;
      T_E64:   return 8'hD8;
      T_ID:    return 8'h9F;
      T_WS:    return 8'h01;
      default: return 8'h05;
    endcase
  endfunction

  wire       wr_ctl  = reg_we && reg_addr[6:2] == 5'd1;
  wire [4:0] widx    = reg_addr[6:2] - 5'd4;
  wire       wr_buf  = reg_we && reg_addr[6:2] >= 5'd4 && reg_addr[6:2] <= 5'd19;
  wire [3:0] new_typ = reg_wdata[20:17];
  wire       start   = wr_ctl && reg_wdata[16] && !busy && !acc_err_in &&
                       valid_of(new_typ) && !(new_typ == T_WS && lock);
  wire       has_adr = typ inside {T_RD, T_PP, T_E4, T_E64};
  wire       poll    = wren_of(typ);
  wire st_t  after_adr = (typ inside {T_PP, T_WS}) ? S_WDAT :
                         (typ inside {T_RD, T_ID, T_RS}) ? S_RDAT : S_GAP;
  wire st_t  ret_end = poll ? S_PCMD : S_IDLE;

  assign busy     = st != S_IDLE;
  assign rx       = {sh[6:0], spi_miso};
  assign bdone    = shifting(st) && hc == 4'd15;
  assign spi_cs_n = !shifting(st);
  assign spi_sck  = hc[0];
  assign spi_mosi = shifting(st) & sh[7];

  always_comb begin
    st_n = st; ret_n = ret; bcnt_n = bcnt; fin = 1'b0;
    case (st)
      S_GAP:  if (gap == 8'd0) begin st_n = ret; fin = (ret == S_IDLE); end
      S_WREN: if (bdone) begin st_n = S_GAP; ret_n = S_OPC; end
      S_OPC:  if (bdone) begin
                bcnt_n = '0; ret_n = ret_end;
                st_n = has_adr ? S_ADR : after_adr;
              end
      S_ADR:  if (bdone) begin
                if (bcnt == 6'd2) begin bcnt_n = '0; st_n = after_adr; ret_n = ret_end; end
                else bcnt_n = bcnt + 6'd1;
              end
      S_WDAT, S_RDAT: if (bdone) begin
                if (bcnt == cnt) begin st_n = S_GAP; ret_n = ret_end; end
                else bcnt_n = bcnt + 6'd1;
              end
      S_PCMD: if (bdone) st_n = S_PRD;
      S_PRD:  if (bdone) begin st_n = S_GAP; ret_n = rx[0] ? S_PCMD : S_IDLE; end
      default: ;
    endcase
  end

  always_comb begin
    case (st_n)
      S_OPC:   tx_n = op_of(typ);
      S_ADR:   tx_n = (bcnt_n[1:0] == 2'd0) ? faddr[23:16] :
                      (bcnt_n[1:0] == 2'd1) ? faddr[15:8] : faddr[7:0];
      S_WDAT:  tx_n = buf_q[bcnt_n[5:2]][{bcnt_n[1:0], 3'b000} +: 8];
      S_PCMD:  tx_n = 8'h05;
      default: tx_n = 8'h00;
    endcase
  end
  assign load = shifting(st_n) && (bdone || !shifting(st));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ret <= S_IDLE; typ <= '0; cnt <= '0; bcnt <= '0;
      hc <= '0; sh <= '0; gap <= '0; faddr <= '0;
      lock <= 1'b0; done <= 1'b0; cerr <= 1'b0; aerr <= 1'b0;
      for (int i = 0; i < NWORDS; i++) buf_q[i] <= '0;
    end else begin
      ret  <= ret_n;
      bcnt <= bcnt_n;
      hc   <= shifting(st) ? hc + 4'd1 : 4'd0;
      if (st_n == S_GAP && st != S_GAP) gap <= 8'(GAP_CYC - 1);
      else if (gap != 8'd0)             gap <= gap - 8'd1;

      if (start) begin
        st <= wren_of(new_typ) ? S_WREN : S_OPC;
        sh <= wren_of(new_typ) ? 8'h06 : op_of(new_typ);
      end else begin
        st <= st_n;
        if (load)                      sh <= tx_n;
        else if (shifting(st) && hc[0]) sh <= rx;
      end

      if (st == S_RDAT && bdone) buf_q[bcnt[5:2]][{bcnt[1:0], 3'b000} +: 8] <= rx;

      if (wr_ctl) begin
        done <= done & ~reg_wdata[0];
        cerr <= cerr & ~reg_wdata[1];
        aerr <= aerr & ~reg_wdata[2];
        lock <= lock | reg_wdata[15];
        if (!busy) begin
          typ <= new_typ;
          cnt <= reg_wdata[29:24];
          if (reg_wdata[16]) begin
            if (acc_err_in) aerr <= 1'b1;
            else if (!start) cerr <= 1'b1;
          end
        end
      end
      if (reg_we && reg_addr[6:2] == 5'd2 && !busy) faddr <= reg_wdata[23:0];
      if (wr_buf && !busy) buf_q[widx[3:0]] <= reg_wdata;
      if (fin) done <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr[6:2])
      5'd1:    reg_rdata = {2'b0, cnt, 3'b0, typ, 1'b0, lock, 9'b0, busy, 2'b0, aerr, cerr, done};
      5'd2:    reg_rdata = {8'h00, faddr};
      default: reg_rdata = (reg_addr[6:2] >= 5'd4 && reg_addr[6:2] <= 5'd19) ? buf_q[widx[3:0]] : 32'h0;
    endcase
  end
endmodule

module spi_hwseq_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [6:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        acc_err_in,
  input logic        busy,
  input logic        lock,
  input logic        aerr,
  input logic        cerr,
  input logic [3:0]  typ,
  input logic [5:0]  cnt,
  input logic        spi_cs_n,
  input logic        spi_sck
);
  wire go_w = reg_we && reg_addr[6:2] == 5'd1 && reg_wdata[16];

  p_sck_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  p_cs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  p_aerr_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go_w && !busy && acc_err_in) |=> (aerr && !busy));
  p_lock_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go_w && !busy && !acc_err_in && lock && reg_wdata[20:17] == 4'd7) |=> (cerr && !busy));
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr[6:2] == 5'd1 && busy) |=> ($stable(typ) && $stable(cnt)));
endmodule

bind spi_hwseq_engine spi_hwseq_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .acc_err_in(acc_err_in), .busy(busy), .lock(lock),
  .aerr(aerr), .cerr(cerr), .typ(typ), .cnt(cnt),
  .spi_cs_n(spi_cs_n), .spi_sck(spi_sck)
);

// File: tb/spi_hwseq_engine_bench.sv
module spi_hwseq_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] reg_addr = '0;
  logic reg_we = 1'b0, acc_err_in = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;

  spi_hwseq_engine u_spi_hwseq_engine (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [8:0] expq[$];
  bit mon_en = 1'b0;
  int bitc = 0, nb = 0, busy_left = 0;
  logic [7:0] rxb = '0, op = '0, txs = '0;
  logic [23:0] fa = '0;

  function automatic logic [7:0] pat(logic [23:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b); expq.push_back({1'b0, b}); endtask
  task automatic mark(); expq.push_back(9'h100); endtask

  // flash model and monitor
  always @(negedge spi_cs_n) begin bitc = 0; nb = 0; txs = 8'h00; end
  always @(posedge spi_sck) begin
    rxb = {rxb[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin
      bitc = 0;
      checks++;
      if (expq.size() == 0) begin
        errors++; $display("FAIL R2 unexpected byte actual=%h expected=none", rxb);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        if (e !== {1'b0, rxb}) begin
          errors++; $display("FAIL R3 spi byte actual=%h expected=%h", rxb, e);
        end
      end
      if (nb == 0) op = rxb;
      if (op == 8'h03 && nb >= 1 && nb <= 3) fa = {fa[15:0], rxb};
      txs = 8'h00;
      if (op == 8'h03 && nb >= 3) txs = pat(fa + 24'(nb - 3));
      if (op == 8'h9F) txs = 8'hA0 + 8'(nb);
      if (op == 8'h05 && nb == 0) begin
        txs = (busy_left > 0) ? 8'h01 : 8'h00;
        if (busy_left > 0) busy_left--;
      end
      nb++;
    end
  end
  always @(negedge spi_sck) begin spi_miso = txs[7]; txs = txs << 1; end
  always @(posedge spi_cs_n) if (mon_en) begin
    checks++;
    if (expq.size() == 0 || expq[0] !== 9'h100) begin
      errors++; $display("FAIL R12 frame end actual=cs_rise expected=%h",
                         expq.size() ? expq[0] : 9'h1FF);
    end else void'(expq.pop_front());
  end

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(logic [6:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask
  function automatic logic [31:0] ctlw(logic [3:0] t, logic [5:0] c, logic [31:0] x);
    return {2'b0, c, 24'h0} | {11'h0, t, 17'h0} | 32'h0001_0000 | x;
  endfunction
  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(7'h04, v);
      if (!v[5]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
    rd(7'h04, v); check("R1 ctl", v, 32'h0);
    rd(7'h08, v); check("R1 addr", v, 32'h0);
    check("R1 cs", {31'h0, spi_cs_n}, 1);
    check("R12 sck", {31'h0, spi_sck}, 0);

    // R2 read 5 bytes
    wr(7'h08, 32'h123456);
    push(8'h03); push(8'h12); push(8'h34); push(8'h56);
    for (int i = 0; i < 5; i++) push(8'h00);
    mark();
    wr(7'h04, ctlw(4'd0, 6'd4, 0));
    rd(7'h04, v); check("R6 busy/go", v, 32'h0400_0020);
    wait_idle();
    rd(7'h04, v); check("R6 done", v & 32'h27, 32'h1);
    rd(7'h10, v); check("R2 word0", v, {pat(24'h123459), pat(24'h123458), pat(24'h123457), pat(24'h123456)});
    rd(7'h14, v); check("R2 word1", v, {24'h0, pat(24'h12345A)});

    // R3 program with two busy polls, R7 clear done on start
    wr(7'h10, 32'h00CCBBAA);
    wr(7'h08, 32'h000100);
    busy_left = 2;
    push(8'h06); mark();
    push(8'h02); push(8'h00); push(8'h01); push(8'h00);
    push(8'hAA); push(8'hBB); push(8'hCC); mark();
    for (int i = 0; i < 3; i++) begin push(8'h05); push(8'h00); mark(); end
    wr(7'h04, ctlw(4'd2, 6'd2, 32'h1));
    rd(7'h04, v); check("R7 done cleared", v & 32'h21, 32'h20);
    wait_idle();
    rd(7'h04, v); check("R3 done", v & 32'h27, 32'h1);
    check("R3 frames", expq.size(), 0);

    // R4 erase 4K and 64K, count ignored
    wr(7'h08, 32'h0AB000);
    push(8'h06); mark(); push(8'h20); push(8'h0A); push(8'hB0); push(8'h00); mark();
    push(8'h05); push(8'h00); mark();
    wr(7'h04, ctlw(4'd3, 6'd63, 32'h7));
    wait_idle();
    check("R4 erase4k", expq.size(), 0);
    push(8'h06); mark(); push(8'hD8); push(8'h0A); push(8'hB0); push(8'h00); mark();
    push(8'h05); push(8'h00); mark();
    wr(7'h04, ctlw(4'd4, 6'd5, 32'h7));
    wait_idle();
    check("R4 erase64k", expq.size(), 0);

    // R5 write status, read status, read id
    wr(7'h10, 32'h0000009C);
    push(8'h06); mark(); push(8'h01); push(8'h9C); mark(); push(8'h05); push(8'h00); mark();
    wr(7'h04, ctlw(4'd7, 6'd0, 32'h7));
    wait_idle();
    check("R5 wrsr", expq.size(), 0);
    busy_left = 1;
    push(8'h05); push(8'h00); mark();
    wr(7'h04, ctlw(4'd8, 6'd0, 32'h7));
    wait_idle();
    rd(7'h10, v); check("R5 rdsr", v, 32'h00000001);
    push(8'h9F); push(8'h00); push(8'h00); mark();
    wr(7'h04, ctlw(4'd6, 6'd1, 32'h7));
    wait_idle();
    rd(7'h10, v); check("R5 rdid", v, 32'h0000A1A0);

    // R8 access error
    acc_err_in = 1'b1;
    wr(7'h04, ctlw(4'd0, 6'd0, 32'h7));
    acc_err_in = 1'b0;
    rd(7'h04, v); check("R8 aerr", v & 32'h27, 32'h4);
    check("R8 cs", {31'h0, spi_cs_n}, 1);
    wr(7'h04, 32'h4);
    rd(7'h04, v); check("R7 w1c aerr", v & 32'h7, 32'h0);

    // R10 invalid type
    wr(7'h04, ctlw(4'd5, 6'd0, 0));
    rd(7'h04, v); check("R10 cerr", v & 32'h27, 32'h2);
    repeat (20) @(negedge clk);
    check("R10 no frame", expq.size(), 0);
    wr(7'h04, 32'h2);

    // R11 go while busy
    wr(7'h08, 32'h000000);
    push(8'h03); push(8'h00); push(8'h00); push(8'h00);
    for (int i = 0; i < 64; i++) push(8'h00);
    mark();
    wr(7'h04, ctlw(4'd0, 6'd63, 0));
    wr(7'h04, ctlw(4'd3, 6'd1, 0));
    wr(7'h08, 32'h55AA55);
    rd(7'h04, v); check("R11 fields", v & 32'h3F1E_0020, 32'h3F00_0020);
    rd(7'h08, v); check("R11 addr", v, 32'h0);
    wait_idle();
    check("R11 no extra", expq.size(), 0);
    rd(7'h4C, v); check("R2 word15", v, {pat(24'd63), pat(24'd62), pat(24'd61), pat(24'd60)});

    // R9 lock
    wr(7'h04, 32'h0000_8001);
    wr(7'h04, 32'h0);
    rd(7'h04, v); check("R9 sticky", v & 32'h8000, 32'h8000);
    wr(7'h04, ctlw(4'd7, 6'd0, 0));
    rd(7'h04, v); check("R9 refuse", v & 32'h27, 32'h2);
    repeat (20) @(negedge clk);
    check("R9 no frame", expq.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule